// File: doc/BRIEF.md
# Dual-Core Mailbox with Hardware Mutex

This block lets two processor cores signal each other through a small register window on one synchronous bus port. It holds two 32-bit message slots, one for each core ID (0 and 1). One core posts a value into the other core's slot, and that slot's interrupt line stays high for as long as the slot holds any nonzero bit. The receiving core acknowledges the message by clearing bits. Each slot can be reached through three addresses. One loads the whole word. One ORs bits into it. One removes bits from it. With the set and clear addresses, a core can change single flags without a read-modify-write race.

The block also holds a single hardware lock. A read of the lock address tries to take it and reports whether it succeeded. A write with bit 0 high gives it back. The lock is a two-state machine. In state FREE, a lock read is the TAKE transition to HELD and returns 1. In state HELD, a lock read returns 0 and the state does not change. In either state, a lock write with bit 0 set is the RELEASE transition to FREE. A lock write with bit 0 clear leaves the state as it is.

Read data is registered and appears on `bus_rdata` in the cycle after the read is issued.

Top module: `core_mailbox`

## Requirements
- R1: After reset, both slots read 0, both interrupt lines are low, the lock is FREE, and `bus_rdata` is 0.
- R2: A write to the slot's load address (slot 0 at 0x00, slot 1 at 0x10) replaces the whole slot word. A read of that address returns the slot word on `bus_rdata` one cycle after the read.
- R3: A write to the slot's set address (0x04 for slot 0, 0x14 for slot 1) ORs the written data into the slot. Zero bits in the data leave the slot bits unchanged.
- R4: A write to the slot's clear address (0x08 for slot 0, 0x18 for slot 1) clears every slot bit where the data has a 1. A write of all zeros leaves the slot unchanged.
- R5: A read of a set or clear address returns the current slot word.
- R6: `irq[k]` is high exactly when slot k is nonzero. It changes on the same clock edge that changes the slot.
- R7: A read of the lock address (0xF8) while the lock is FREE returns 1 in bit 0 (all other bits 0) and moves the lock to HELD.
- R8: A read of the lock address while the lock is HELD returns 0, and the lock stays HELD.
- R9: A write to the lock address with bit 0 = 1 moves the lock to FREE. A write with bit 0 = 0 has no effect.
- R10: A read of any other address returns 0. A write to any other address changes no slot and does not change the lock.
- R11: When read and write enables are both high in one cycle, the write takes effect. The read has no side effect, and `bus_rdata` is 0 in the next cycle.
- R12: A write to one slot never changes the other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write enable |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid in the cycle after a read |
| irq | output | 2 | Per-slot interrupt, bit k high while slot k is nonzero |

## Verification
Slot contents, the interrupt lines and the lock state all change on the edge that samples the write or read. Read data arrives one edge after the read is sampled. The bench drives every access on a falling edge. It checks `irq` and the lock effects at the next falling edge. It compares `bus_rdata` at that same falling edge, before the following rising edge returns it to 0. Each read is compared against a model value captured before that read's own lock side effect is applied. This means a read that takes the lock is expected to return the value from before the take.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    // Offsets inside one slot's window; slot k starts at k * SLOT_STRIDE.
    localparam int unsigned OFS_LOAD    = 0;
    localparam int unsigned OFS_SET     = 4;
    localparam int unsigned OFS_CLEAR   = 8;
    localparam int unsigned SLOT_STRIDE = 16;
    localparam int unsigned LOCK_OFS    = 248;

    typedef enum logic {
        LOCK_FREE = 1'b0,
        LOCK_HELD = 1'b1
    } lock_state_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned N_SLOTS = 2
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    input  logic               rd,
    output logic [N_SLOTS-1:0] slot_load,
    output logic [N_SLOTS-1:0] slot_set,
    output logic [N_SLOTS-1:0] slot_clear,
    output logic [N_SLOTS-1:0] slot_rd_hit,
    output logic               lock_take,
    output logic               lock_write,
    output logic               rd_active
);
    localparam logic [ADDR_W-1:0] LOCK_ADDR = ADDR_W'(LOCK_OFS);

    // A write in the same cycle suppresses the read and its side effect.
    assign rd_active  = rd & ~wr;
    assign lock_take  = rd_active & (addr == LOCK_ADDR);
    assign lock_write = wr & (addr == LOCK_ADDR);

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot_dec
        localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(k * SLOT_STRIDE);
        localparam logic [ADDR_W-1:0] A_LOAD  = BASE + ADDR_W'(OFS_LOAD);
        localparam logic [ADDR_W-1:0] A_SET   = BASE + ADDR_W'(OFS_SET);
        localparam logic [ADDR_W-1:0] A_CLEAR = BASE + ADDR_W'(OFS_CLEAR);

        logic hit_load, hit_set, hit_clear;
        assign hit_load  = (addr == A_LOAD);
        assign hit_set   = (addr == A_SET);
        assign hit_clear = (addr == A_CLEAR);

        assign slot_load[k]   = wr & hit_load;
        assign slot_set[k]    = wr & hit_set;
        assign slot_clear[k]  = wr & hit_clear;
        assign slot_rd_hit[k] = rd_active & (hit_load | hit_set | hit_clear);
    end
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              set,
    input  logic              clear,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] value,
    output logic              irq
);
    logic [DATA_W-1:0] value_q, value_d;
    logic [DATA_W-1:0] set_mask, clr_mask;
    logic              irq_q;

    // Clear wins over set for overlapping bits if both ever coincide.
    always_comb begin
        set_mask = set   ? wdata : '0;
        clr_mask = clear ? wdata : '0;
        if (load) begin
            value_d = wdata;
        end else begin
            value_d = (value_q | set_mask) & ~clr_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
            irq_q   <= 1'b0;
        end else begin
            value_q <= value_d;
            irq_q   <= (value_d != '0);
        end
    end

    assign value = value_q;
    assign irq   = irq_q;
endmodule

// File: rtl/mbx_lock.sv
module mbx_lock
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic take,
    input  logic release_req,
    output logic is_free
);
    lock_state_t state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LOCK_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: TAKE (FREE -> HELD on read), RELEASE (any -> FREE on write 1).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOCK_FREE: begin
                if (take) state_d = LOCK_HELD;
            end
            LOCK_HELD: begin
                if (release_req) state_d = LOCK_FREE;
            end
            default: state_d = LOCK_FREE;
        endcase
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            LOCK_FREE: is_free = 1'b1;
            LOCK_HELD: is_free = 1'b0;
            default:   is_free = 1'b0;
        endcase
    end
endmodule

// File: rtl/core_mailbox.sv
module core_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned N_SLOTS = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [N_SLOTS-1:0] irq
);
    logic [N_SLOTS-1:0] slot_load, slot_set, slot_clear, slot_rd_hit;
    logic               lock_take, lock_write, rd_active;
    logic               lock_free;
    logic [DATA_W-1:0]  slot_val [N_SLOTS];
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  rdata_q;

    mbx_decode #(.ADDR_W(ADDR_W), .N_SLOTS(N_SLOTS)) u_decode (
        .addr        (bus_addr),
        .wr          (bus_wr),
        .rd          (bus_rd),
        .slot_load   (slot_load),
        .slot_set    (slot_set),
        .slot_clear  (slot_clear),
        .slot_rd_hit (slot_rd_hit),
        .lock_take   (lock_take),
        .lock_write  (lock_write),
        .rd_active   (rd_active)
    );

    for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
        mbx_slot #(.DATA_W(DATA_W)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (slot_load[k]),
            .set   (slot_set[k]),
            .clear (slot_clear[k]),
            .wdata (bus_wdata),
            .value (slot_val[k]),
            .irq   (irq[k])
        );
    end

    mbx_lock u_lock (
        .clk         (clk),
        .rst_n       (rst_n),
        .take        (lock_take),
        .release_req (lock_write & bus_wdata[0]),
        .is_free     (lock_free)
    );

    // Read selection: lock state is sampled before this read's take.
    always_comb begin
        rd_mux = '0;
        if (lock_take) begin
            rd_mux = DATA_W'(lock_free);
        end else begin
            for (int k = 0; k < N_SLOTS; k++) begin
                if (slot_rd_hit[k]) rd_mux = slot_val[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            rdata_q <= rd_active ? rd_mux : '0;
        end
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/core_mailbox_chk.sv
module core_mailbox_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [1:0]        irq,
    input logic [DATA_W-1:0] slot0,
    input logic [DATA_W-1:0] slot1,
    input logic              lock_free
);
    // R3
    set0_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(4)) |=> slot0 == ($past(slot0) | $past(bus_wdata)));

    // R4
    clear1_andn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(24)) |=> slot1 == ($past(slot1) & ~$past(bus_wdata)));

    // R6
    irq_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq == {slot1 != '0, slot0 != '0});

    // R7
    lock_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(248) && lock_free)
        |=> (bus_rdata == DATA_W'(1)) && !lock_free);

    // R8
    lock_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == ADDR_W'(248) && !lock_free)
        |=> (bus_rdata == '0) && !lock_free);

    // R9
    lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(248) && bus_wdata[0]) |=> lock_free);

    // R11
    rd_wr_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_wr) |=> bus_rdata == '0);

    // R12
    slot_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[ADDR_W-1:4] == '0) |=> $stable(slot1));
endmodule

bind core_mailbox core_mailbox_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq[1:0]),
    .slot0     (slot_val[0]),
    .slot1     (slot_val[1]),
    .lock_free (lock_free)
);

// File: tb/core_mailbox_bench.sv
module core_mailbox_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    bit          finished = 1'b0;

    // Reference model state.
    logic [31:0] m_slot [2];
    logic        m_free;

    always #5 clk = ~clk;

    core_mailbox u_core_mailbox (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00, 8'h04, 8'h08: return m_slot[0];
            8'h10, 8'h14, 8'h18: return m_slot[1];
            8'hF8:               return {31'b0, m_free};
            default:             return '0;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'h00, 8'h10: return "R2";
            8'h04, 8'h08, 8'h14, 8'h18: return "R5";
            8'hF8: return m_free ? "R7" : "R8";
            default: return "R10";
        endcase
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_slot[0] = d;
            8'h04: m_slot[0] = m_slot[0] | d;
            8'h08: m_slot[0] = m_slot[0] & ~d;
            8'h10: m_slot[1] = d;
            8'h14: m_slot[1] = m_slot[1] | d;
            8'h18: m_slot[1] = m_slot[1] & ~d;
            8'hF8: if (d[0]) m_free = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check_irq(input string req);
        check(req, {30'b0, irq}, {30'b0, m_slot[1] != '0, m_slot[0] != '0});
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d, input string req);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
        @(negedge clk);
        bus_wr = 1'b0;
        model_write(a, d);
        check_irq(req);
    endtask

    task automatic do_read(input logic [7:0] a, input string req);
        logic [31:0] exp;
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
        exp = model_read(a);
        if (a == 8'hF8) m_free = 1'b0;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, exp);
    endtask

    task automatic do_clash(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        model_write(a, d);
        check("R11", bus_rdata, 32'h0);
    endtask

    function automatic logic [7:0] pick_addr(input int unsigned r);
        case (r % 11)
            0: return 8'h00;  1: return 8'h04;  2: return 8'h08;
            3: return 8'h10;  4: return 8'h14;  5: return 8'h18;
            6, 7: return 8'hF8;
            8: return 8'h0C;  9: return 8'h21;
            default: return 8'hFC;
        endcase
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_slot[0] = '0; m_slot[1] = '0; m_free = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1", bus_rdata, 32'h0);
        check_irq("R1");
        do_read(8'h00, "R1");
        do_read(8'h10, "R1");

        // R2 load and read back, R6 irq follows
        do_write(8'h00, 32'hA5A5_0001, "R6");
        do_read(8'h00, "R2");
        // R12 other slot untouched
        do_read(8'h10, "R12");
        // R3 set alias, zero write no change
        do_write(8'h14, 32'h0000_0300, "R3");
        do_write(8'h14, 32'h0, "R3");
        do_read(8'h10, "R3");
        // R5 alias reads
        do_read(8'h14, "R5");
        do_read(8'h08, "R5");
        // R4 clear alias, zero write no effect, clear to zero drops irq
        do_write(8'h08, 32'h0, "R4");
        do_read(8'h00, "R4");
        do_write(8'h08, 32'hFFFF_FFFF, "R6");
        do_read(8'h04, "R4");
        // R7 / R8 / R9 lock sequence
        do_read(8'hF8, "R7");
        do_read(8'hF8, "R8");
        do_write(8'hF8, 32'hFFFF_FFFE, "R9");
        do_read(8'hF8, "R9");
        do_write(8'hF8, 32'h1, "R9");
        do_read(8'hF8, "R9");
        do_read(8'hF8, "R8");
        do_write(8'hF8, 32'h1, "R9");
        // R10 unmapped
        do_write(8'h0C, 32'hDEAD_BEEF, "R10");
        do_write(8'hF4, 32'h1, "R10");
        do_read(8'h0C, "R10");
        do_read(8'h00, "R10");
        do_read(8'h10, "R10");
        do_read(8'hF8, "R10");
        do_write(8'hF8, 32'h1, "R9");
        // R11 read+write together: write lands, lock not taken
        do_clash(8'hF8, 32'h0);
        do_read(8'hF8, "R11");
        do_clash(8'h10, 32'h1234_5678);
        do_read(8'h10, "R11");

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            int unsigned r = $urandom;
            logic [7:0]  a = pick_addr($urandom);
            logic [31:0] d;
            case ($urandom % 4)
                0: d = '0;
                1: d = 32'h1 << ($urandom % 32);
                default: d = $urandom;
            endcase
            case (r % 8)
                0, 1, 2: do_write(a, d, "R6");
                7:       do_clash(a, d);
                default: do_read(a, read_tag(a));
            endcase
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule